// File: doc/BRIEF.md
# In-Place RGB-to-Gray Frame Sweeper

This block turns a colour image stored in a frame buffer into a grayscale image in the same buffer. After a trigger it visits every pixel address once, in ascending order. For each pixel it reads the stored word, adds the three 8-bit colour fields, divides the sum by three, and writes that mean back into all three fields at the same address.

The block drives a single-port synchronous RAM with a read strobe, a write strobe, one shared address and a write-data bus. It takes back read data one cycle after a read. Each pixel costs three cycles: read, compute and write. The pixel word is 24 bits. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0. The frame size is 320 by 240 pixels by default and can be set through parameters.

Top module: `rgb_gray_sweeper`

## Requirements
- R1: While reset is applied and in the first cycle after it, `done_o`, `mem_rd_o` and `mem_wr_o` are low.
- R2: Each word written holds g = floor((R+G+B)/3) in all three fields. R, G and B are the fields of the word read from the same address: bits 23:16, 15:8 and 7:0. For example, FFFFFF gives FFFFFF, FFFFFE gives FEFEFE, 010100 gives 000000, and 800000 gives 2A2A2A.
- R3: The write for a pixel comes two cycles after its read, at the same address.
- R4: A sweep reads and writes every address from 0 to W*H-1 exactly once, in ascending order.
- R5: `done_o` is high for exactly one cycle. That cycle is the one right after the write to address W*H-1. A sweep started by a single-cycle `start_i` therefore raises `done_o` 3*W*H cycles after the edge that samples `start_i`.
- R6: `start_i` is ignored while a sweep is running. The sweep does not restart, and its sequence and timing do not change.
- R7: While idle and with `start_i` low, the block issues no reads and no writes.
- R8: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.
- R9: A pixel whose three fields are already equal is written back unchanged, so a second sweep leaves a gray image as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sweep trigger, sampled while idle |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | AW | Pixel address, AW = clog2(W*H) |
| mem_rd_o | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 24 | Gray pixel to write |
| mem_rdata_i | input | 24 | Read data from the RAM |

## Verification
The embedded properties check the following on every cycle:
- reads and writes never overlap;
- addresses stay inside the frame;
- every write trails its read by two cycles at the same address;
- each read after the first directly follows a write;
- the done pulse is a single cycle that follows the write to the last address.

Some behaviours can only be shown by the bench scenarios:
- the arithmetic of the averaged value over edge-case sums;
- coverage of the whole frame;
- the ignored mid-sweep trigger;
- the total sweep length;
- the idle quiet period.

These scenarios run on a 4x3 frame, with every written word compared against a value the bench computes.

// File: rtl/rgb_gray_sweeper.sv
module rgb_gray_sweeper #(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  localparam int PIX = IMG_W * IMG_H,
  localparam int AW  = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [23:0]   mem_wdata_o,
  input  logic [23:0]   mem_rdata_i
);

  localparam logic [AW-1:0] LAST = AW'(PIX - 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CALC, S_WRITE, S_DONE} state_t;

  state_t      state;
  logic [AW-1:0] addr;
  logic [7:0]  gray;
  logic [9:0]  sum;
  logic [9:0]  quot;

  assign sum  = {2'b0, mem_rdata_i[23:16]} + {2'b0, mem_rdata_i[15:8]} + {2'b0, mem_rdata_i[7:0]};
  assign quot = sum / 10'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      addr  <= '0;
      gray  <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start_i) begin
                   state <= S_READ;
                   addr  <= '0;
                 end
        S_READ:  state <= S_CALC;
        S_CALC:  begin
                   gray  <= quot[7:0];
                   state <= S_WRITE;
                 end
        S_WRITE: if (addr == LAST) state <= S_DONE;
                 else begin
                   addr  <= addr + 1'b1;
                   state <= S_READ;
                 end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = addr;
  assign mem_rd_o    = (state == S_READ);
  assign mem_wr_o    = (state == S_WRITE);
  assign mem_wdata_o = {gray, gray, gray};
  assign done_o      = (state == S_DONE);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o)); // R8

  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> (mem_addr_o <= LAST)); // R4

  AST_WRITE_TRAILS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> ($past(mem_rd_o, 2) && $past(mem_addr_o, 2) == mem_addr_o)); // R3

  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_addr_o != '0) |-> ($past(mem_wr_o) && $past(mem_addr_o) + 1'b1 == mem_addr_o)); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_wr_o) && $past(mem_addr_o) == LAST)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

endmodule

// File: tb/test_rgb_gray_sweeper.sv
module test_rgb_gray_sweeper;
  localparam int W = 4;
  localparam int H = 3;
  localparam int N = W * H;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o, mem_rd_o, mem_wr_o;
  logic [AW-1:0] mem_addr_o;
  logic [23:0] mem_wdata_o, mem_rdata_i;

  logic [23:0] mem [N];
  logic [23:0] orig [N];
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [23:0] ld_data = '0;

  int checks = 0, errors = 0;
  int mchecks = 0, merrors = 0;
  int exp_rd = 0, exp_wr = 0;

  always #10 clk = ~clk;

  rgb_gray_sweeper #(.IMG_W(W), .IMG_H(H)) i_rgb_gray_sweeper (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
  end

  function automatic logic [23:0] gray_of(input logic [23:0] p);
    int s;
    s = int'(p[23:16]) + int'(p[15:8]) + int'(p[7:0]);
    s = s / 3;
    return {s[7:0], s[7:0], s[7:0]};
  endfunction

  function automatic logic [23:0] pattern(input int p, input int i);
    case (p)
      0: return {3{8'(i * 20)}};
      1: case (i % 6)
           0: return 24'hFFFFFF;
           1: return 24'h000000;
           2: return 24'h010100;
           3: return 24'h010101;
           4: return 24'hFFFFFE;
           default: return 24'h800000;
         endcase
      default: return {8'(i * 53 + 7), 8'(i * 101 + 3), 8'(i * 197 + 11)};
    endcase
  endfunction

  // bus monitor: ordering, write data and strobe exclusion
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_o && mem_wr_o) begin
        merrors++;
        $display("FAIL R8: rd and wr both high at addr %0d (expected only one)", mem_addr_o);
      end
      if (mem_rd_o) begin
        mchecks++;
        if (int'(mem_addr_o) != exp_rd) begin
          merrors++;
          $display("FAIL R4: read addr %0d expected %0d", mem_addr_o, exp_rd);
        end
        exp_rd++;
      end
      if (mem_wr_o) begin
        mchecks += 2;
        if (int'(mem_addr_o) != exp_wr) begin
          merrors++;
          $display("FAIL R3: write addr %0d expected %0d", mem_addr_o, exp_wr);
        end
        if (mem_wdata_o != gray_of(orig[mem_addr_o])) begin
          merrors++;
          $display("FAIL R2: wdata %h expected %h at addr %0d", mem_wdata_o, gray_of(orig[mem_addr_o]), mem_addr_o);
        end
        exp_wr++;
      end
      if (done_o) begin
        exp_rd = 0;
        exp_wr = 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input int p);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = pattern(p, i);
      orig[i] = pattern(p, i);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic sweep(input string req, input bit poke);
    int cnt;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (!done_o && cnt < 1000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (poke && (cnt == 5 || cnt == 17)) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    check({req, " R5 sweep length"}, cnt, 3 * N);
    @(negedge clk);
    check("R5 done single cycle", done_o, 0);
    for (int i = 0; i < N; i++)
      check({req, " R2 stored gray"}, mem[i], gray_of(orig[i]));
  endtask

  initial begin
    #100000000;
    $display("FAIL watchdog: run did not finish (expected completion)");
    $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done in reset", done_o, 0);
    check("R1 rd in reset", mem_rd_o, 0);
    check("R1 wr in reset", mem_wr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", done_o, 0);
    check("R1 wr after reset", mem_wr_o, 0);

    load(0);
    sweep("ramp", 1'b0);
    load(1);
    sweep("corners", 1'b0);
    load(2);
    sweep("R6 mixed with mid-sweep start", 1'b1);
    for (int i = 0; i < N; i++) orig[i] = mem[i];
    sweep("R9 repeat", 1'b0);
    for (int i = 0; i < N; i++)
      check("R9 gray unchanged", mem[i], orig[i]);

    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R7 idle no rd", mem_rd_o, 0);
      check("R7 idle no wr", mem_wr_o, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end
endmodule